// File: doc/BRIEF.md
# Feed-Sequence Protected Watchdog Timer

This block guards a processor against hanging. Software programs a timeout value, arms the block and then has to refresh it regularly with a fixed two-word key sequence. A down-counter is clocked by the peripheral clock through a divide-by-four prescaler. If it reaches zero before it is refreshed, the block raises a sticky interrupt and records the event in a status flag. When reset mode is armed, it also sends a one-cycle reset request to the chip reset logic.

Once arming is switched on, software cannot switch it off. Only a power-on style hardware reset or the reset that the watchdog itself causes clears it. The block treats a key sequence that is broken or wrong like an expiry, so a runaway program that writes random values to the key register ends up in a reset rather than in a refresh. A debug freeze bit lets an attached debugger stop the countdown while the core is halted.

Register map (word index on `bus_addr`): 0 = control, 1 = reload value, 2 = key register (write only, reads 0), 3 = live count.

Top module: `wdog_guard`

## Requirements
- R1: While running and not frozen, the count falls by exactly one every 4 clock cycles. It does not change in any other cycle unless reloaded or reset.
- R2: A write to the reload register (index 1) stores the value. A value below 256 is stored as 256. After reset the register reads 256.
- R3: Writing 1 to control bit 0 (arm) or bit 1 (reset mode) sets that bit. Writing 0 has no effect. Both bits clear only on `rst_n` low or a `soft_rst_n` low cycle.
- R4: Writing 0xAA to index 2 followed, as the very next bus access, by 0x55 to index 2 is a valid key sequence. When armed, it copies the reload value into the counter and starts the countdown. Arming alone, or a stray 0x55, starts nothing. The count reads 0 after reset.
- R5: When the count reaches zero after the reload value's number of ticks, `irq` rises and control bit 2 (expired flag) sets. `sys_rst_req` pulses high for exactly one cycle only if arm and reset mode are both set.
- R6: When armed, a 0xAA key followed by any other access or any other value counts as a key error. The block acts exactly as on expiry. When not armed, key writes have no effect.
- R7: The expired flag survives `soft_rst_n`. It is cleared by writing control with bit 2 = 0 or by `rst_n`. `irq` stays high until `rst_n`.
- R8: With control bit 3 (freeze) set and `dbg_halt` high, the count holds. With bit 3 clear, `dbg_halt` has no effect.
- R9: Reading index 3 returns the live count and disturbs nothing, as long as no 0xAA key is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Hardware reset, active low, clears everything |
| soft_rst_n | input | 1 | Synchronous system reset (including the one this block requests); keeps the flag and irq |
| bus_valid | input | 1 | Bus access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| dbg_halt | input | 1 | Debugger halt indication |
| irq | output | 1 | Sticky expiry interrupt |
| sys_rst_req | output | 1 | One-cycle reset request |

## Verification
The bench measures the prescaler phase exactly. It reads the count 40 cycles after a refresh and checks the interrupt one cycle before and one cycle after the 1024th cycle. A design that ticked on the wrong phase, expired at zero plus one tick, or skipped the minimum clamp would miss these exact values. The key-sequence checks cover several cases: a stray 0x55, a read placed between the two keys, a wrong second key, and key writes while disarmed. A decoder that ignored non-key accesses, or that faulted while disarmed, would be caught. The bench also clears arm by writing 0, applies a system reset with the flag set, and raises the halt input with the freeze bit clear. These catch a block that can be disabled, one that loses the flag, or one that freezes unconditionally.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam logic [1:0] IDX_CTRL  = 2'd0;
    localparam logic [1:0] IDX_LOAD  = 2'd1;
    localparam logic [1:0] IDX_KICK  = 2'd2;
    localparam logic [1:0] IDX_COUNT = 2'd3;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;

    localparam int BIT_ARM    = 0;
    localparam int BIT_RSTEN  = 1;
    localparam int BIT_FLAG   = 2;
    localparam int BIT_FREEZE = 3;
endpackage

// File: rtl/wdg_feed_seq.sv
module wdg_feed_seq
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       active_i,
    input  logic       access_i,
    input  logic       kick_wr_i,
    input  logic [7:0] data_i,
    output logic       ok_o,
    output logic       bad_o
);
    typedef struct packed {
        logic armed;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        ok_o  = 1'b0;
        bad_o = 1'b0;
        if (clr_i || !active_i) begin
            seq_d.armed = 1'b0;
        end else if (access_i) begin
            if (seq_q.armed) begin
                seq_d.armed = 1'b0;
                if (kick_wr_i && data_i == KEY_SECOND) ok_o  = 1'b1;
                else                                   bad_o = 1'b1;
            end else if (kick_wr_i && data_i == KEY_FIRST) begin
                seq_d.armed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    // R4
    armed_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_i) |=> !seq_q.armed);
endmodule

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
    parameter int PRE_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic adv_i,
    output logic tick_o
);
    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } pre_t;

    pre_t pre_d, pre_q;

    always_comb begin
        pre_d  = pre_q;
        tick_o = adv_i && !clr_i && (&pre_q.phase);
        if (clr_i)      pre_d.phase = '0;
        else if (adv_i) pre_d.phase = pre_q.phase + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R1
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !clr_i) |=> $stable(pre_q.phase));
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          tick_i,
    output logic [CW-1:0] count_o,
    output logic          expire_o
);
    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d    = cnt_q;
        expire_o = 1'b0;
        if (clr_i) begin
            cnt_d.cnt = '0;
        end else if (load_i) begin
            cnt_d.cnt = load_val_i;
        end else if (tick_i && cnt_q.cnt != '0) begin
            cnt_d.cnt = cnt_q.cnt - ONE;
            expire_o  = (cnt_q.cnt == ONE);
        end
    end

    assign count_o = cnt_q.cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R1
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !tick_i && !clr_i) |=> $stable(cnt_q.cnt));
    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && !clr_i && cnt_q.cnt != '0) |=> (cnt_q.cnt == $past(cnt_q.cnt) - ONE));
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
    import wdg_pkg::*;
#(
    parameter int CW       = 32,
    parameter int MIN_LOAD = 256,
    parameter int PRE_W    = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst_n,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        dbg_halt,
    output logic        irq,
    output logic        sys_rst_req
);
    localparam logic [CW-1:0] LOAD_FLOOR = CW'(MIN_LOAD);

    typedef struct packed {
        logic          arm;
        logic          rsten;
        logic          freeze;
        logic          flag;
        logic          irq;
        logic          rstp;
        logic          run;
        logic [CW-1:0] load;
    } wd_t;

    localparam wd_t WD_RST = '{arm: 1'b0, rsten: 1'b0, freeze: 1'b0, flag: 1'b0,
                               irq: 1'b0, rstp: 1'b0, run: 1'b0, load: LOAD_FLOOR};

    wd_t wd_d, wd_q;

    logic          wr_ctrl, wr_load, wr_kick, srst;
    logic          feed_ok, feed_bad, tick, expire, frozen, trip;
    logic [CW-1:0] count;

    assign srst    = !soft_rst_n;
    assign wr_ctrl = bus_valid && bus_write && bus_addr == IDX_CTRL;
    assign wr_load = bus_valid && bus_write && bus_addr == IDX_LOAD;
    assign wr_kick = bus_valid && bus_write && bus_addr == IDX_KICK;
    assign frozen  = wd_q.freeze && dbg_halt;
    assign trip    = expire || feed_bad;

    wdg_feed_seq u_feed (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (srst),
        .active_i  (wd_q.arm),
        .access_i  (bus_valid),
        .kick_wr_i (wr_kick),
        .data_i    (bus_wdata[7:0]),
        .ok_o      (feed_ok),
        .bad_o     (feed_bad)
    );

    wdg_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (feed_ok || srst),
        .adv_i  (wd_q.run && !frozen),
        .tick_o (tick)
    );

    wdg_countdown #(.CW(CW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (srst),
        .load_i     (feed_ok),
        .load_val_i (wd_q.load),
        .tick_i     (tick),
        .count_o    (count),
        .expire_o   (expire)
    );

    always_comb begin
        wd_d      = wd_q;
        wd_d.rstp = 1'b0;
        if (wr_ctrl) begin
            wd_d.arm    = wd_q.arm   || bus_wdata[BIT_ARM];
            wd_d.rsten  = wd_q.rsten || bus_wdata[BIT_RSTEN];
            wd_d.freeze = bus_wdata[BIT_FREEZE];
            if (!bus_wdata[BIT_FLAG]) wd_d.flag = 1'b0;
        end
        if (wr_load) begin
            wd_d.load = (bus_wdata[CW-1:0] < LOAD_FLOOR) ? LOAD_FLOOR : bus_wdata[CW-1:0];
        end
        if (feed_ok) wd_d.run = 1'b1;
        if (trip) begin
            wd_d.run  = 1'b0;
            wd_d.irq  = 1'b1;
            wd_d.flag = 1'b1;
            wd_d.rstp = wd_q.arm && wd_q.rsten;
        end
        if (srst) begin
            wd_d.arm    = 1'b0;
            wd_d.rsten  = 1'b0;
            wd_d.freeze = 1'b0;
            wd_d.run    = 1'b0;
            wd_d.rstp   = 1'b0;
            wd_d.load   = LOAD_FLOOR;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            IDX_CTRL: begin
                bus_rdata[BIT_ARM]    = wd_q.arm;
                bus_rdata[BIT_RSTEN]  = wd_q.rsten;
                bus_rdata[BIT_FLAG]   = wd_q.flag;
                bus_rdata[BIT_FREEZE] = wd_q.freeze;
            end
            IDX_LOAD:  bus_rdata = 32'(wd_q.load);
            IDX_KICK:  bus_rdata = '0;
            IDX_COUNT: bus_rdata = 32'(count);
            default:   bus_rdata = '0;
        endcase
    end

    assign irq         = wd_q.irq;
    assign sys_rst_req = wd_q.rstp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wd_q <= WD_RST;
        else        wd_q <= wd_d;
    end

    // R2
    load_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_q.load >= LOAD_FLOOR);
    // R3
    arm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_q.arm && soft_rst_n) |=> wd_q.arm);
    // R5
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> !sys_rst_req);
    // R5
    rst_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> (wd_q.arm && wd_q.rsten && irq));
    // R6
    feed_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        feed_bad |=> (irq && wd_q.flag));
    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> irq);
    // R7
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_q.flag && !wr_ctrl) |=> wd_q.flag);
    // R8
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !feed_ok && soft_rst_n) |=> $stable(count));
endmodule

// File: tb/wdog_guard_bench.sv
module wdog_guard_bench;
    localparam time HALF = 2.5ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst_n = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dbg_halt = 1'b0;
    logic        irq, sys_rst_req;

    int n_chk = 0;
    int n_err = 0;
    int n_rst = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [31:0] exp;
        bit          cmp;
        int          req;
    } exp_t;
    exp_t        sbq[$];
    logic [31:0] last_rd;

    always #HALF clk = ~clk;

    wdog_guard u_wdog_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst_n  (soft_rst_n),
        .bus_valid   (bus_valid),
        .bus_write   (bus_write),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .dbg_halt    (dbg_halt),
        .irq         (irq),
        .sys_rst_req (sys_rst_req)
    );

    always @(posedge clk) if (sys_rst_req) n_rst++;

    task automatic chk(input bit ok, input int req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor: compares each read mid-cycle
    always begin
        @(negedge clk);
        #1;
        if (bus_valid && !bus_write) begin
            if (sbq.size() == 0) begin
                chk(1'b0, 9, bus_rdata, 32'hx);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                last_rd = bus_rdata;
                if (e.cmp) chk(bus_rdata == e.exp, e.req, bus_rdata, e.exp);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] e, input int req);
        sbq.push_back('{exp: e, cmp: 1'b1, req: req});
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [31:0] v);
        sbq.push_back('{exp: '0, cmp: 1'b0, req: 9});
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        v = last_rd;
    endtask

    task automatic feed();
        wr(2'd2, 32'hAA);
        wr(2'd2, 32'h55);
    endtask

    task automatic hw_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 2 * HALF);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, b, c;
        int n0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state: R3 R2 R4 R5
        chk(irq == 1'b0, 5, 32'(irq), 0);
        chk(sys_rst_req == 1'b0, 5, 32'(sys_rst_req), 0);
        rd(2'd0, 32'h0, 3);
        rd(2'd1, 32'd256, 2);
        rd(2'd3, 32'h0, 4);

        // R2 clamp and plain store
        wr(2'd1, 32'd10);
        rd(2'd1, 32'd256, 2);
        wr(2'd1, 32'h1234);
        rd(2'd1, 32'h1234, 2);
        wr(2'd1, 32'd256);

        // R6 keys while disarmed do nothing
        wr(2'd2, 32'hAA);
        wr(2'd1, 32'd256);
        chk(irq == 1'b0, 6, 32'(irq), 0);

        // R3 arm and reset mode set-only
        wr(2'd0, 32'h3);
        rd(2'd0, 32'h3, 3);
        repeat (20) @(negedge clk);
        // R4 arming alone starts nothing
        rd(2'd3, 32'h0, 4);
        chk(irq == 1'b0, 4, 32'(irq), 0);
        wr(2'd0, 32'h0);
        rd(2'd0, 32'h3, 3);
        // R4 stray second key
        wr(2'd2, 32'h55);
        rd(2'd3, 32'h0, 4);

        // R1 timing after valid feed (feed edge E0)
        feed();
        repeat (40) @(negedge clk);
        rd(2'd3, 32'd246, 1);
        repeat (982) @(negedge clk);
        // R5 one cycle before expiry
        chk(irq == 1'b0, 5, 32'(irq), 0);
        rd(2'd3, 32'd1, 5);
        chk(irq == 1'b1, 5, 32'(irq), 1);
        rd(2'd0, 32'h7, 5);
        chk(n_rst == 1, 5, 32'(n_rst), 1);
        repeat (5) @(negedge clk);
        chk(n_rst == 1 && !sys_rst_req, 5, 32'(n_rst), 1);

        // R7 flag survives system reset, R3 arm cleared by it
        soft_rst_n = 1'b0;
        @(negedge clk);
        soft_rst_n = 1'b1;
        rd(2'd0, 32'h4, 7);
        chk(irq == 1'b1, 7, 32'(irq), 1);
        wr(2'd0, 32'h4);
        rd(2'd0, 32'h4, 7);
        wr(2'd0, 32'h0);
        rd(2'd0, 32'h0, 7);
        chk(irq == 1'b1, 7, 32'(irq), 1);
        hw_reset();
        chk(irq == 1'b0, 7, 32'(irq), 0);

        // R8 freeze while halted
        wr(2'd0, 32'hB);
        feed();
        repeat (10) @(negedge clk);
        dbg_halt = 1'b1;
        peek(2'd3, a);
        repeat (30) @(negedge clk);
        peek(2'd3, b);
        chk(a == b, 8, b, a);
        dbg_halt = 1'b0;
        repeat (20) @(negedge clk);
        peek(2'd3, c);
        chk(c < b, 8, c, b);
        // R8 halt ignored without freeze bit
        wr(2'd0, 32'h3);
        dbg_halt = 1'b1;
        peek(2'd3, a);
        repeat (20) @(negedge clk);
        peek(2'd3, b);
        chk(b < a, 8, b, a);
        dbg_halt = 1'b0;

        // R4 reload in mid-count, R9 reads disturb nothing
        feed();
        rd(2'd3, 32'd256, 4);
        rd(2'd3, 32'd256, 9);
        chk(irq == 1'b0, 9, 32'(irq), 0);

        // R6 access between keys is a fault
        n0 = n_rst;
        wr(2'd2, 32'hAA);
        peek(2'd3, a);
        chk(irq == 1'b1, 6, 32'(irq), 1);
        repeat (2) @(negedge clk);
        chk(n_rst == n0 + 1, 6, 32'(n_rst), 32'(n0 + 1));
        rd(2'd0, 32'h7, 6);

        // R6 wrong second key, R5 no reset request without reset mode
        hw_reset();
        wr(2'd0, 32'h1);
        feed();
        n0 = n_rst;
        wr(2'd2, 32'hAA);
        wr(2'd2, 32'h12);
        chk(irq == 1'b1, 6, 32'(irq), 1);
        repeat (3) @(negedge clk);
        chk(n_rst == n0, 5, 32'(n_rst), 32'(n0));
        rd(2'd0, 32'h5, 6);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule